// File: doc/BRIEF.md
# Serial-in latched-output shift register

This block turns a serial bit stream into a parallel word. It has two registers on two independent clocks. A shift stage takes one bit per rising edge of the shift clock. A holding register copies the whole shift stage on a rising edge of the storage clock. The parallel outputs change only when the holding register loads, so the word that is being shifted in never shows on them. A ripple of half-formed words is avoided in this way.

The shift stage has an active-low asynchronous clear. The clear reaches only the shift stage. The last shift bit is brought out as a serial cascade output, so several instances can be chained to form a wider word. An active-low output enable controls the parallel outputs.

For synthesis the parallel side is presented in two parts. One is a data bus that always carries the holding register. The other is a per-bit drive-enable. A parameter selects whether the top also models the high-impedance state on a third bus for simulation. If it does not, that bus copies the data bus.

Top module: `sipo_latch_out`

## Requirements
- R1: On every rising edge of `sh_clk` while `clr_n` is high, shift bit i moves to bit i+1, and `ser_i` is loaded into bit 0. Bit 0 is the entry stage.
- R2: On a rising edge of `st_clk`, the holding register takes the full shift-stage value. Between storage edges, `par_dat_o` does not change, whatever happens to the shift stage.
- R3: While `clr_n` is low, every shift bit is zero at once, without any clock edge. Shift-clock edges during that time have no effect.
- R4: The clear leaves the holding register untouched. The next storage edge after a clear copies the all-zero shift value.
- R5: `ser_o` always equals the last shift bit (bit WIDTH-1), whatever the level of `oe_n`.
- R6: With `oe_n` high, every bit of `par_en_o` is 0 and `par_o` is high impedance. With `oe_n` low, every bit of `par_en_o` is 1 and `par_o` equals `par_dat_o`.
- R7: When both clocks rise on the same edge, the holding register takes the value the shift stage had before that edge's shift. The parallel word therefore trails the shift stage by one pulse.
- R8: The first bit shifted in after a clear reaches bit WIDTH-1, and so `ser_o`, after WIDTH shift edges. Before the first storage edge, the holding register holds the parameter `HOLD_INIT`, which defaults to all zero.
- R9: With `ser_o` of one instance wired to `ser_i` of a second, and the clocks shared, the pair behaves as a single shift stage of twice the width. The second instance holds the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sh_clk | input | 1 | Shift clock, rising edge |
| st_clk | input | 1 | Storage clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stage, active low |
| ser_i | input | 1 | Serial data into shift bit 0 |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_o | output | 1 | Cascade output, last shift bit |
| par_dat_o | output | WIDTH | Holding register contents |
| par_en_o | output | WIDTH | Per-bit drive enable for the parallel outputs |
| par_o | output | WIDTH | Parallel outputs, high impedance when disabled (when TRI_MODEL=1) |

## Verification
The shift assertions assume that `clr_n` never changes in the same instant as a `sh_clk` rising edge. The storage assertion assumes that the shift stage is settled at each `st_clk` edge, apart from the same-edge case in R7. The bench drives each clock as a gated copy of its free-running clock. The gates open and close only while that clock is low, so no clock edge is clipped. The clear is pulsed a couple of nanoseconds after a falling edge, well away from any rising edge. The random run mixes shift-only pulses, storage-only pulses, shared pulses, enable toggles and occasional clears, and checks the two chained instances against a 16-bit bench model.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // default word width of one instance
  localparam int unsigned SIPO_DEF_W = 8;
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sh_clk,
  input  logic             clr_n,
  input  logic             ser_i,
  output logic [WIDTH-1:0] sh_q
);
  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) sh_q <= '0;
    else        sh_q <= {sh_q[WIDTH-2:0], ser_i};
  end

  // checker state: set by a clear (and at start), dropped by each shift edge
  logic clr_hit = 1'b1;
  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) clr_hit <= 1'b1;
    else        clr_hit <= 1'b0;
  end

  // R1: contents move up one place per edge
  a_r1_shift_up: assert property (@(posedge sh_clk) disable iff (!clr_n)
    (!clr_hit && $past(clr_n)) |-> sh_q[WIDTH-1:1] == $past(sh_q[WIDTH-2:0]));

  // R1: entry stage takes the serial input
  a_r1_load_bit0: assert property (@(posedge sh_clk) disable iff (!clr_n)
    (!clr_hit && $past(clr_n)) |-> sh_q[0] == $past(ser_i));
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned     WIDTH     = 8,
  parameter logic [WIDTH-1:0] HOLD_INIT = '0
) (
  input  logic             st_clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] hold_r = HOLD_INIT;

  always_ff @(posedge st_clk) hold_r <= d_i;
  assign q_o = hold_r;

  logic st_seen = 1'b0;
  always_ff @(posedge st_clk) st_seen <= 1'b1;

  // R2: after a storage edge the register shows what was offered on it
  a_r2_capture: assert property (@(posedge st_clk) disable iff (!st_seen)
    1'b1 |-> q_o == $past(d_i));
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] hold_i,
  input  logic             oe_n,
  output logic [WIDTH-1:0] dat_o,
  output logic [WIDTH-1:0] en_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign dat_o[i] = hold_i[i];
    assign en_o[i]  = ~oe_n;
  end

  // R6: enables switch as one group
  always_comb begin
    a_r6_en_uniform: assert ((en_o == '0) || (en_o == '1));
  end
endmodule

// File: rtl/sipo_latch_out.sv
module sipo_latch_out #(
  parameter int unsigned      WIDTH     = sipo_pkg::SIPO_DEF_W,
  parameter logic [WIDTH-1:0] HOLD_INIT = '0,
  parameter bit               TRI_MODEL = 1'b1
) (
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             ser_i,
  input  logic             oe_n,
  output logic             ser_o,
  output logic [WIDTH-1:0] par_dat_o,
  output logic [WIDTH-1:0] par_en_o,
  output logic [WIDTH-1:0] par_o
);
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] hold_q;

  sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .sh_clk (sh_clk),
    .clr_n  (clr_n),
    .ser_i  (ser_i),
    .sh_q   (sh_q)
  );

  sipo_hold_reg #(.WIDTH(WIDTH), .HOLD_INIT(HOLD_INIT)) u_hold (
    .st_clk (st_clk),
    .d_i    (sh_q),
    .q_o    (hold_q)
  );

  sipo_out_drv #(.WIDTH(WIDTH)) u_drv (
    .hold_i (hold_q),
    .oe_n   (oe_n),
    .dat_o  (par_dat_o),
    .en_o   (par_en_o)
  );

  // R5: cascade taken straight from the last stage
  assign ser_o = sh_q[WIDTH-1];

  if (TRI_MODEL) begin : g_tri
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign par_o[i] = par_en_o[i] ? par_dat_o[i] : 1'bz;
    end
  end else begin : g_plain
    assign par_o = par_dat_o;
  end
endmodule

// File: tb/sim_sipo_latch_out.sv
module sim_sipo_latch_out;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sh_g = 1'b0, st_g = 1'b0;
  logic sh_clk, st_clk;
  assign sh_clk = clk & sh_g;
  assign st_clk = clk & st_g;

  logic clr_n = 1'b1, oe_n = 1'b1, ser = 1'b0;
  logic so0, so1;
  logic [7:0] d0, d1, e0, e1, p0, p1;

  sipo_latch_out #(.WIDTH(8)) u0 (
    .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .ser_i(ser), .oe_n(oe_n),
    .ser_o(so0), .par_dat_o(d0), .par_en_o(e0), .par_o(p0));
  sipo_latch_out #(.WIDTH(8)) u1 (
    .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .ser_i(so0), .oe_n(oe_n),
    .ser_o(so1), .par_dat_o(d1), .par_en_o(e1), .par_o(p1));

  int n_vec = 0, n_bad = 0;
  logic [15:0] ch = '0;  // model of the chained shift stages
  logic [15:0] st = '0;  // model of the chained holding registers

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [7:0] en_exp;
    en_exp = oe_n ? 8'h00 : 8'hFF;
    chk({tag, " par_dat u0"}, d0, st[7:0]);
    chk({tag, " par_dat u1 R9"}, d1, st[15:8]);
    chk({tag, " ser_o u0 R5"}, {7'd0, so0}, {7'd0, ch[7]});
    chk({tag, " ser_o u1 R9"}, {7'd0, so1}, {7'd0, ch[15]});
    chk({tag, " en u0 R6"}, e0, en_exp);
    chk({tag, " en u1 R6"}, e1, en_exp);
    if (!oe_n) begin
      chk({tag, " pins u0 R6"}, p0, st[7:0]);
      chk({tag, " pins u1 R6"}, p1, st[15:8]);
    end
  endtask

  // one pulse on the chosen clocks, gates changed only while clk is low
  task automatic step(input logic s, input logic dsh, input logic dst);
    @(negedge clk);
    ser = s; sh_g = dsh; st_g = dst;
    if (dst) st = ch;
    if (dsh && clr_n) ch = {ch[14:0], s};
    @(negedge clk);
    sh_g = 1'b0; st_g = 1'b0;
    #1;
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    #2 clr_n = 1'b0;
    ch = '0;
    #1;
  endtask

  task automatic clear_release();
    @(negedge clk);
    #2 clr_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    #2;
    // R8: holding register starts at HOLD_INIT (zero); R6 outputs disabled
    chk("R8 init u0", d0, 8'h00);
    chk("R8 init u1", d1, 8'h00);
    chk("R6 init en", e0, 8'h00);

    clear_pulse();
    chk("R3 clear ser_o", {7'd0, so0}, 8'h00);
    clear_release();

    // R8: a single one travels to the last stage in eight edges
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0);
    chk("R8 not yet at top", {7'd0, so0}, 8'h00);
    step(1'b0, 1'b1, 1'b0);
    chk("R8 first bit at top", {7'd0, so0}, 8'h01);
    chk("R2 no store yet", d0, 8'h00);
    step(1'b0, 1'b0, 1'b1);
    oe_n = 1'b0; #1;
    chk("R2 stored word", d0, 8'h80);
    chk("R6 pins driven", p0, 8'h80);
    chk_all("R2");

    // R5: cascade follows the top bit with outputs disabled
    oe_n = 1'b1; #1;
    step(1'b1, 1'b1, 1'b0);
    chk_all("R5");

    // R3/R4: clear keeps the holding register, shift edges ignored while low
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R4 stored ones", d0, 8'hFF);
    clear_pulse();
    chk("R4 hold kept on clear", d0, 8'hFF);
    step(1'b1, 1'b1, 1'b0);
    chk("R3 shift ignored in clear", {7'd0, so0}, 8'h00);
    clear_release();
    step(1'b0, 1'b0, 1'b1);
    chk("R4 zeros copied", d0, 8'h00);
    chk_all("R3");

    // R7: shared edges store the pre-shift word
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    chk("R7 lags one pulse", d0, 8'hFF);
    chk_all("R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic r_ser, r_sh, r_st;
      r_ser = 1'($urandom);
      r_sh  = ($urandom % 4) != 0;
      r_st  = ($urandom % 3) == 0;
      oe_n  = 1'($urandom);
      if (($urandom % 40) == 0) begin
        clear_pulse();
        chk_all("R3 random");
        clear_release();
      end
      step(r_ser, r_sh, r_st);
      chk_all("R1/R2 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule